// File: doc/BRIEF.md
# Recursive Twiddle Factor Generator

This block produces the cosine and sine of the angles 2πn/N for n = 0, 1, 2, … for use by an FFT datapath. A full-size angle ROM is not used. Each new value comes from a second-order recurrence, x(n) = 2·cos(θ)·x(n−1) − x(n−2). It needs only one step constant per transform length and a seed pair. Rounding error would build up in such a loop. To stop this, a compact table keeps the three low bits of the exact value for every index. Each freshly computed value is nudged by a small signed correction, so its low bits match the table before it is fed back. The history therefore never drifts.

A pulse on the start input picks the transform length and restarts the sequence at index 0. Each advance pulse then steps one index forward. The new pair appears one cycle after either pulse, and a valid flag marks that cycle. The cosine lane keeps 23-bit state with unity at 2^21 and is rounded to a 16-bit output. The sine lane keeps 16-bit state with unity at 2^14. Both outputs use the scale 1.0 = 16384, and the sine is taken with a positive sign.

Top module: `twiddle_gen`

## Requirements
- R1: While reset is held and in the first cycle after release, valid_o is 0 and cos_o and sin_o are both 0.
- R2: In the cycle after a start pulse, valid_o is 1, cos_o is 16384 and sin_o is 0, and the length code present with the pulse is the one used from then on.
- R3: In the cycle after an accepted advance pulse, valid_o is 1 and the outputs hold index k+1, where k is the index that was showing. For index k of length N, let C = floor(cos(2πk/N)·2^21 + 0.5). Then cos_o = floor((C + 64)/128) and sin_o = floor(sin(2πk/N)·2^14 + 0.5), both two's complement.
- R4: Length code c on len_sel_i (2 bits) selects N = 2^(3+c), so codes 0, 1, 2 and 3 give 8, 16, 32 and 64 points.
- R5: After index N−1, the next advance shows index 0, and the sequence repeats without limit.
- R6: In any cycle with neither start nor advance, valid_o is 0 in the following cycle and cos_o and sin_o keep their values.
- R7: Advance pulses that come before the first start after reset are ignored: valid_o stays 0 and the outputs stay 0.
- R8: When start and advance are high in the same cycle, the start is taken and index 0 of the new length is shown.
- R9: Every value written back into the recurrence history has the three low bits of the exact value of its index. As a result, the outputs of R3 stay exact for any number of steps, including at least four full periods of the 64-point sequence.
- R10: A start pulse in the middle of a sequence restarts at index 0 with the newly given length, whatever the earlier length was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Restart the sequence at index 0 and latch the length code |
| len_sel_i | input | 2 | Length code, N = 2^(3+code) |
| adv_i | input | 1 | Step to the next index |
| valid_o | output | 1 | High for one cycle when a new index is shown |
| cos_o | output | 16 | Cosine of the current index, 1.0 = 16384 |
| sin_o | output | 16 | Sine of the current index, 1.0 = 16384 |

## Verification
Restart and stepping can be requested in the same cycle. The bench provokes this with both pulses together, both at the start of a sequence and in the middle of one. It expects the outputs of index 0 of the new length, never the stepped index. A pseudo-random mix of start, advance and idle cycles, with random length codes, then drives a behavioural model that recomputes every expected pair from floating-point trigonometry. The bench compares valid_o, cos_o and sin_o against that model on every clock, so any drift in the history or any wrong choice between the two pulses shows up as an exact mismatch.

// File: rtl/twg_pkg.sv
package twg_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Exact value of cos or sin(2*pi*k/n), scaled by 2^frac, rounded to nearest.
  function automatic int fixed_trig(input int k, input int n, input int frac, input bit use_sin);
    real ang;
    real v;
    ang = TWO_PI * real'(k) / real'(n);
    v   = use_sin ? $sin(ang) : $cos(ang);
    return $rtoi($floor(v * real'(longint'(1) << frac) + 0.5));
  endfunction

  // One recurrence step: round(2*k*cur / 2^kfrac) - prv.
  function automatic longint recur_next(input longint k, input longint cur,
                                        input longint prv, input int kfrac);
    longint prod;
    prod = k * cur;
    return ((prod + (longint'(1) << (kfrac - 2))) >>> (kfrac - 1)) - prv;
  endfunction

  // Signed 3-bit nudge that forces the low bits of raw to want.
  function automatic longint lsb_fix(input longint raw, input logic [2:0] want);
    logic [2:0] d;
    logic [2:0] have;
    have = raw[2:0];
    d    = want - have;
    return raw + longint'(signed'({{61{d[2]}}, d}));
  endfunction

  // Round to nearest by dropping 'drop' low bits (arithmetic).
  function automatic longint drop_round(input longint v, input int drop);
    return (v + (longint'(1) << (drop - 1))) >>> drop;
  endfunction

  // Limit a length code to the largest supported one.
  function automatic int clamp_code(input int code, input int top);
    return (code > top) ? top : code;
  endfunction

endpackage

// File: rtl/twg_step_rom.sv
module twg_step_rom #(
  parameter int MIN_LOG2 = 3,
  parameter int NUM_LEN  = 4,
  parameter int LSW      = 2,
  parameter int K_W      = 26,
  parameter int K_FRAC   = 24,
  parameter int COS_W    = 23,
  parameter int SIN_W    = 16
) (
  input  logic [LSW-1:0]          sel_i,
  output logic signed [K_W-1:0]   k_o,
  output logic signed [COS_W-1:0] cos1_o,
  output logic signed [SIN_W-1:0] sin1_o
);
  localparam int SLOTS    = 1 << LSW;
  localparam int COS_FRAC = COS_W - 2;
  localparam int SIN_FRAC = SIN_W - 2;

  logic signed [K_W-1:0]   k_tab   [SLOTS];
  logic signed [COS_W-1:0] cos_tab [SLOTS];
  logic signed [SIN_W-1:0] sin_tab [SLOTS];

  // Unused code slots repeat the longest length.
  for (genvar j = 0; j < SLOTS; j++) begin : g_len
    localparam int LJ = (j < NUM_LEN) ? j : NUM_LEN - 1;
    localparam int NP = 1 << (MIN_LOG2 + LJ);
    localparam int KV = twg_pkg::fixed_trig(1, NP, K_FRAC, 1'b0);
    localparam int CV = twg_pkg::fixed_trig(1, NP, COS_FRAC, 1'b0);
    localparam int SV = twg_pkg::fixed_trig(1, NP, SIN_FRAC, 1'b1);
    assign k_tab[j]   = K_W'(KV);
    assign cos_tab[j] = COS_W'(CV);
    assign sin_tab[j] = SIN_W'(SV);
  end

  assign k_o    = k_tab[sel_i];
  assign cos1_o = cos_tab[sel_i];
  assign sin1_o = sin_tab[sel_i];
endmodule

// File: rtl/twg_corr_rom.sv
module twg_corr_rom #(
  parameter int AW       = 6,
  parameter int COS_FRAC = 21,
  parameter int SIN_FRAC = 14
) (
  input  logic [AW-1:0] addr_i,
  output logic [2:0]    cos_lsb_o,
  output logic [2:0]    sin_lsb_o
);
  localparam int DEPTH = 1 << AW;

  logic [2:0] cos_tab [DEPTH];
  logic [2:0] sin_tab [DEPTH];

  // Low three bits of the exact values at the finest angle grid.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int CV = twg_pkg::fixed_trig(i, DEPTH, COS_FRAC, 1'b0);
    localparam int SV = twg_pkg::fixed_trig(i, DEPTH, SIN_FRAC, 1'b1);
    assign cos_tab[i] = 3'(CV);
    assign sin_tab[i] = 3'(SV);
  end

  assign cos_lsb_o = cos_tab[addr_i];
  assign sin_lsb_o = sin_tab[addr_i];
endmodule

// File: rtl/twg_lane.sv
module twg_lane #(
  parameter int W      = 16,
  parameter int K_W    = 26,
  parameter int K_FRAC = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic signed [W-1:0] seed0_i,
  input  logic signed [W-1:0] seed1_i,
  input  logic signed [K_W-1:0] k_i,
  input  logic [2:0]          want_i,
  output logic signed [W-1:0] cur_o
);
  localparam int RW = W + 1;

  logic signed [W-1:0]  h_a;     // value at the shown index
  logic signed [W-1:0]  h_b;     // value one index ahead
  logic signed [RW-1:0] raw_w;   // plain recurrence result
  logic signed [RW-1:0] fix_w;   // result after low-bit correction

  always_comb begin
    raw_w = RW'(twg_pkg::recur_next(longint'(k_i), longint'(h_b), longint'(h_a), K_FRAC));
    fix_w = RW'(twg_pkg::lsb_fix(longint'(raw_w), want_i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_a <= '0;
      h_b <= '0;
    end else if (load_i) begin
      h_a <= seed0_i;
      h_b <= seed1_i;
    end else if (step_i) begin
      h_a <= h_b;
      h_b <= W'(fix_w);
    end
  end

  assign cur_o = h_a;

  // R9
  lane_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (h_b[2:0] == $past(want_i)));

  // R3
  lane_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (h_a == $past(h_b)));

  // R3
  lane_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (fix_w[RW-1] == fix_w[RW-2]));
endmodule

// File: rtl/twiddle_gen.sv
module twiddle_gen #(
  parameter int MIN_LOG2 = 3,
  parameter int MAX_LOG2 = 6,
  parameter int SIN_W    = 16,
  parameter int COS_W    = 23,
  parameter int OUT_W    = 16,
  parameter int K_W      = 26,
  parameter int K_FRAC   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       len_sel_i,
  input  logic             adv_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] cos_o,
  output logic [OUT_W-1:0] sin_o
);
  localparam int NUM_LEN  = MAX_LOG2 - MIN_LOG2 + 1;
  localparam int LSW      = 2;
  localparam int AW       = MAX_LOG2;
  localparam int COS_FRAC = COS_W - 2;
  localparam int SIN_FRAC = SIN_W - 2;
  localparam int DROP     = COS_W - OUT_W;
  localparam int ONE_OUT  = 1 << (OUT_W - 2);

  logic           armed_q;
  logic [LSW-1:0] lsel_q;
  logic [AW-1:0]  idx_q;
  logic           valid_q;

  // Named events for the checks
  logic           go_step;
  logic [LSW-1:0] rom_sel;
  logic [AW-1:0]  idx_mask;
  logic [AW-1:0]  idx_next;
  logic [AW-1:0]  ahead2;
  logic [AW-1:0]  corr_addr;

  logic signed [K_W-1:0]   k_step;
  logic signed [COS_W-1:0] cos_seed1;
  logic signed [SIN_W-1:0] sin_seed1;
  logic [2:0]              cos_want;
  logic [2:0]              sin_want;
  logic signed [COS_W-1:0] cos_cur;
  logic signed [SIN_W-1:0] sin_cur;

  always_comb begin
    go_step   = adv_i && armed_q && !start_i;
    rom_sel   = start_i ? LSW'(twg_pkg::clamp_code(int'(len_sel_i), NUM_LEN - 1)) : lsel_q;
    idx_mask  = AW'((1 << (MIN_LOG2 + int'(lsel_q))) - 1);
    idx_next  = (idx_q + AW'(1)) & idx_mask;
    ahead2    = (idx_q + AW'(2)) & idx_mask;
    corr_addr = AW'(ahead2 << (NUM_LEN - 1 - int'(lsel_q)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lsel_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start_i || go_step;
      if (start_i) begin
        armed_q <= 1'b1;
        lsel_q  <= LSW'(twg_pkg::clamp_code(int'(len_sel_i), NUM_LEN - 1));
        idx_q   <= '0;
      end else if (go_step) begin
        idx_q   <= idx_next;
      end
    end
  end

  twg_step_rom #(
    .MIN_LOG2(MIN_LOG2), .NUM_LEN(NUM_LEN), .LSW(LSW),
    .K_W(K_W), .K_FRAC(K_FRAC), .COS_W(COS_W), .SIN_W(SIN_W)
  ) u_step (
    .sel_i (rom_sel),
    .k_o   (k_step),
    .cos1_o(cos_seed1),
    .sin1_o(sin_seed1)
  );

  twg_corr_rom #(
    .AW(AW), .COS_FRAC(COS_FRAC), .SIN_FRAC(SIN_FRAC)
  ) u_corr (
    .addr_i   (corr_addr),
    .cos_lsb_o(cos_want),
    .sin_lsb_o(sin_want)
  );

  twg_lane #(.W(COS_W), .K_W(K_W), .K_FRAC(K_FRAC)) u_cos (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_i),
    .step_i (go_step),
    .seed0_i(COS_W'(1 << COS_FRAC)),
    .seed1_i(cos_seed1),
    .k_i    (k_step),
    .want_i (cos_want),
    .cur_o  (cos_cur)
  );

  twg_lane #(.W(SIN_W), .K_W(K_W), .K_FRAC(K_FRAC)) u_sin (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_i),
    .step_i (go_step),
    .seed0_i('0),
    .seed1_i(sin_seed1),
    .k_i    (k_step),
    .want_i (sin_want),
    .cur_o  (sin_cur)
  );

  assign valid_o = valid_q;
  assign sin_o   = OUT_W'(sin_cur);
  assign cos_o   = OUT_W'(twg_pkg::drop_round(longint'(cos_cur), DROP));

  // R2
  start_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && sin_o == '0 && cos_o == OUT_W'(ONE_OUT)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !adv_i) |=> (!valid_o && $stable(cos_o) && $stable(sin_o)));

  // R7
  unarmed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !start_i) |=> (!valid_o && $stable(cos_o) && $stable(sin_o)));

  // R5
  index_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_step && idx_q == idx_mask) |=> (idx_q == '0));

  // R8
  start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && adv_i) |=> (idx_q == '0 && sin_o == '0));
endmodule

// File: tb/twiddle_gen_bench.sv
module twiddle_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        adv = 1'b0;
  logic [1:0]  lsel = 2'd0;
  logic        valid;
  logic [15:0] cosv;
  logic [15:0] sinv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural model
  bit m_armed = 1'b0;
  int m_n     = 8;
  int m_idx   = 0;
  bit m_valid = 1'b0;
  int m_cos   = 0;
  int m_sin   = 0;
  int seed    = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  twiddle_gen u_twiddle_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .len_sel_i(lsel), .adv_i(adv),
    .valid_o(valid), .cos_o(cosv), .sin_o(sinv)
  );

  function automatic int want_sin(int k, int n);
    real a;
    a = 6.283185307179586 * real'(k) / real'(n);
    return $rtoi($floor($sin(a) * 16384.0 + 0.5));
  endfunction

  function automatic int want_cos(int k, int n);
    real a;
    int c23;
    a = 6.283185307179586 * real'(k) / real'(n);
    c23 = $rtoi($floor($cos(a) * 2097152.0 + 0.5));
    return $rtoi($floor(real'(c23 + 64) / 128.0));
  endfunction

  task automatic check(string tag);
    int ac;
    int as_;
    ac  = int'($signed(cosv));
    as_ = int'($signed(sinv));
    checks++;
    if (valid !== m_valid || ac != m_cos || as_ != m_sin) begin
      fails++;
      $display("FAIL %s: got valid=%0b cos=%0d sin=%0d, expected valid=%0b cos=%0d sin=%0d (n=%0d idx=%0d)",
               tag, valid, ac, as_, m_valid, m_cos, m_sin, m_n, m_idx);
    end
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge.
  task automatic cyc(bit s, int code, bit a, string tag);
    start = s;
    lsel  = code[1:0];
    adv   = a;
    @(posedge clk);
    if (s) begin
      m_armed = 1'b1;
      m_n     = 1 << (3 + code);
      m_idx   = 0;
      m_valid = 1'b1;
      m_cos   = want_cos(m_idx, m_n);
      m_sin   = want_sin(m_idx, m_n);
    end else if (a && m_armed) begin
      m_idx   = (m_idx + 1) % m_n;
      m_valid = 1'b1;
      m_cos   = want_cos(m_idx, m_n);
      m_sin   = want_sin(m_idx, m_n);
    end else begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    start = 1'b0;
    adv   = 1'b0;
    check(tag);
  endtask

  function automatic int next_rand(int s);
    int x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >>> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    check("R1 after release");
    // R7: stepping before any start
    for (int i = 0; i < 4; i++) cyc(1'b0, 0, 1'b1, "R7 advance unarmed");
    cyc(1'b0, 0, 1'b0, "R6 idle unarmed");
    // R2, R4, R3, R5: 8-point run through two wraps
    cyc(1'b1, 0, 1'b0, "R2 start 8-point");
    for (int i = 0; i < 18; i++) cyc(1'b0, 0, 1'b1, "R3 R4 R5 step 8-point");
    // R6: holds between steps
    for (int i = 0; i < 6; i++) cyc(1'b0, 0, (i % 3) == 2, "R6 hold between steps");
    // R10: restart mid-sequence at 16 and 32 points
    cyc(1'b1, 1, 1'b0, "R10 restart 16-point");
    for (int i = 0; i < 20; i++) cyc(1'b0, 1, 1'b1, "R4 R5 step 16-point");
    cyc(1'b1, 2, 1'b0, "R10 restart 32-point");
    for (int i = 0; i < 40; i++) cyc(1'b0, 2, 1'b1, "R4 R5 step 32-point");
    // R9: long 64-point run, over four periods
    cyc(1'b1, 3, 1'b0, "R2 start 64-point");
    for (int i = 0; i < 4 * 64 + 9; i++) cyc(1'b0, 3, 1'b1, "R9 R5 long 64-point");
    // R8: start and advance together, mid-sequence and right after start
    cyc(1'b1, 1, 1'b1, "R8 start with advance");
    cyc(1'b1, 1, 1'b1, "R8 start with advance again");
    cyc(1'b0, 1, 1'b1, "R3 step after collision");
    cyc(1'b1, 0, 1'b1, "R8 start with advance new length");
    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      bit s;
      bit a;
      int c;
      seed = next_rand(seed);
      s = ((seed & 63) == 0);
      a = ((seed >>> 8) & 3) != 0;
      c = (seed >>> 12) & 3;
      cyc(s, c, a, "R3 R8 R10 mixed traffic");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run still busy, expected completion before the cycle limit");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule